// File: doc/BRIEF.md
# Sequential-Access Memory Read Port

This block is the device side of a pin-driven read mode for an on-chip byte-wide program memory. No address bus exists: an internal address counter picks the location. A clear pin forces that counter to zero, and every rising edge on a step pin moves it forward by one. The memory can therefore only be walked in order. To return to an earlier byte, the reader clears the counter and steps forward again.

The reader pulls the active-low output-enable pin low to see the addressed byte on the 8-bit data port. The port drives only while output enable is low and the program-control pin is held high (inactive). The port is modelled as a data vector plus a drive-enable flag, which the pad ring turns into a tri-state buffer. The clear, step, output-enable and program-control pins are asynchronous to the system clock, so each passes through a two-flop synchronizer. Step edges are detected after synchronization, so one external pulse advances the counter exactly once.

The memory array is behavioural. It is filled from a computed pattern so that every byte read back can be predicted.

Top module: `seqrd_port`

## Requirements
- R1: After synchronous reset, `port_drive` is 0, `port_data` is 0 and the address counter is 0.
- R2: While the synchronized clear pin is high, the address counter is 0. After clear, the next read returns the byte at location 0.
- R3: Each low-to-high transition of `step_pin` advances the counter by exactly one, however long the pin stays high.
- R4: Location `a` holds `((a*29 + (a>>4)) mod 256) XOR SEED`, with `SEED` defaulting to 8'h5A. Port bit n carries stored bit n, where bit 0 is the least significant.
- R5: `port_drive` is 1 only while `oe_n_pin` is low and `prog_n_pin` is high. Whenever `port_drive` is 0, `port_data` is 0.
- R6: The counter is `ADDR_W` bits wide (default 12). A step at the top address (all ones) wraps it to 0.
- R7: Clear takes priority over step. Step edges that arrive while clear is high, including one in the same cycle as clear, leave the counter at 0.
- R8: Toggling output enable, or pulling it low repeatedly, does not move the counter. Two reads without a step in between return the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_pin | input | 1 | Asynchronous clear request for the address counter, active high |
| step_pin | input | 1 | Asynchronous step input; idles low, and each rising edge advances the counter |
| oe_n_pin | input | 1 | Asynchronous active-low output enable |
| prog_n_pin | input | 1 | Program-control pin; must be high for read mode |
| port_data | output | 8 | Byte at the current address, registered; zero while not driving |
| port_drive | output | 1 | Pad drive enable for the data port; the port is high-impedance when this is 0 |

## Verification
The hardest condition to reach is the counter wrapping from its top address to zero. From the ports it takes a full sweep of 2^ADDR_W step pulses after a clear. The bench drives short pulses: three clocks high and three clocks low, enough to pass the synchronizer cleanly. It then reads location 4095 just before the wrap and location 0 just after it. The clear-priority case is set up by raising clear and step in the same cycle, releasing clear while step is still high, and checking that no advance is seen.

// File: rtl/seqrd_pkg.sv
package seqrd_pkg;
  localparam int BYTE_W = 8;

  // Content of location a: ((a*29 + (a>>4)) mod 256) ^ seed
  function automatic logic [BYTE_W-1:0] fill_byte(input int unsigned a,
                                                  input logic [BYTE_W-1:0] seed);
    logic [31:0] t;
    t = a * 32'd29 + (a >> 4);
    return t[BYTE_W-1:0] ^ seed;
  endfunction
endpackage

// File: rtl/seqrd_sync.sv
module seqrd_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage[s] <= RST_VAL;
        else     stage[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage[s] <= RST_VAL;
        else     stage[s] <= stage[s-1];
      end
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/seqrd_addr_ctr.sv
module seqrd_addr_ctr #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              step_lvl,
  output logic [ADDR_W-1:0] addr,
  output logic              step_rise
);
  logic step_prev;

  always_ff @(posedge clk) begin
    if (rst) step_prev <= 1'b0;
    else     step_prev <= step_lvl;
  end

  assign step_rise = step_lvl & ~step_prev;

  // Clear wins over a step edge in the same cycle; natural wrap at the top.
  always_ff @(posedge clk) begin
    if (rst || clr)     addr <= '0;
    else if (step_rise) addr <= addr + 1'b1;
  end
endmodule

// File: rtl/seqrd_rom.sv
module seqrd_rom #(
  parameter int ADDR_W = 12,
  parameter logic [seqrd_pkg::BYTE_W-1:0] SEED = 8'h5A
) (
  input  logic                          clk,
  input  logic [ADDR_W-1:0]             addr,
  output logic [seqrd_pkg::BYTE_W-1:0]  q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [seqrd_pkg::BYTE_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = seqrd_pkg::fill_byte(i, SEED);
  end

  // Registered read so the array maps onto block RAM.
  always_ff @(posedge clk) q <= mem[addr];
endmodule

// File: rtl/seqrd_out_stage.sv
module seqrd_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] rom_q,
  input  logic         oe_n_s,
  input  logic         prog_n_s,
  output logic [W-1:0] data,
  output logic         drive
);
  logic enable;
  assign enable = ~oe_n_s & prog_n_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      data  <= '0;
      drive <= 1'b0;
    end else begin
      drive <= enable;
      data  <= enable ? rom_q : '0;
    end
  end
endmodule

// File: rtl/seqrd_port.sv
module seqrd_port #(
  parameter int ADDR_W = 12,
  parameter logic [7:0] SEED = 8'h5A,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr_pin,
  input  logic       step_pin,
  input  logic       oe_n_pin,
  input  logic       prog_n_pin,
  output logic [7:0] port_data,
  output logic       port_drive
);
  localparam int NPIN = 4;
  // pin order inside the synchronizer: {prog_n, oe_n, step, clr}
  localparam logic [NPIN-1:0] PIN_IDLE = 4'b1100;

  logic [NPIN-1:0]   pins_s;
  logic              clr_s, step_s, oe_n_s, prog_n_s;
  logic [ADDR_W-1:0] addr;
  logic              step_rise;
  logic [7:0]        rom_q;

  seqrd_sync #(.N(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({prog_n_pin, oe_n_pin, step_pin, clr_pin}),
    .q   (pins_s)
  );

  assign clr_s    = pins_s[0];
  assign step_s   = pins_s[1];
  assign oe_n_s   = pins_s[2];
  assign prog_n_s = pins_s[3];

  seqrd_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr_s),
    .step_lvl  (step_s),
    .addr      (addr),
    .step_rise (step_rise)
  );

  seqrd_rom #(.ADDR_W(ADDR_W), .SEED(SEED)) u_rom (
    .clk  (clk),
    .addr (addr),
    .q    (rom_q)
  );

  seqrd_out_stage #(.W(8)) u_out (
    .clk      (clk),
    .rst      (rst),
    .rom_q    (rom_q),
    .oe_n_s   (oe_n_s),
    .prog_n_s (prog_n_s),
    .data     (port_data),
    .drive    (port_drive)
  );
endmodule

// File: rtl/seqrd_port_chk.sv
module seqrd_port_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              clr_s,
  input logic              step_rise,
  input logic [ADDR_W-1:0] addr,
  input logic              oe_n_s,
  input logic              prog_n_s,
  input logic [7:0]        port_data,
  input logic              port_drive
);
  // R2 / R7: clear forces the counter to zero, step or not
  p_clear_zero_r2: assert property (@(posedge clk) disable iff (rst)
    clr_s |=> addr == '0);

  // R3: a detected edge moves the counter by one
  p_step_one_r3: assert property (@(posedge clk) disable iff (rst)
    (!clr_s && step_rise) |=> addr == ADDR_W'($past(addr) + 1'b1));

  // R3: an edge is seen for one cycle only
  p_rise_single_r3: assert property (@(posedge clk) disable iff (rst)
    step_rise |=> !step_rise);

  // R8: no edge and no clear keeps the address
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!clr_s && !step_rise) |=> $stable(addr));

  // R6: top address wraps to zero
  p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (!clr_s && step_rise && addr == '1) |=> addr == '0);

  // R5: drive follows read-mode qualification
  p_drive_on_r5: assert property (@(posedge clk) disable iff (rst)
    (!oe_n_s && prog_n_s) |=> port_drive);

  p_drive_off_r5: assert property (@(posedge clk) disable iff (rst)
    (oe_n_s || !prog_n_s) |=> (!port_drive && port_data == 8'h00));
endmodule

bind seqrd_port seqrd_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .clr_s      (clr_s),
  .step_rise  (step_rise),
  .addr       (addr),
  .oe_n_s     (oe_n_s),
  .prog_n_s   (prog_n_s),
  .port_data  (port_data),
  .port_drive (port_drive)
);

// File: tb/seqrd_port_test.sv
`timescale 1ns/1ps
module seqrd_port_test;
  localparam int ADDR_W = 12;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam logic [7:0] SEED = 8'h5A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr_pin = 1'b0, step_pin = 1'b0, oe_n_pin = 1'b1, prog_n_pin = 1'b1;
  logic [7:0] port_data;
  logic port_drive;

  int total = 0;
  int bad   = 0;
  int model_addr = 0;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic       strobe = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  seqrd_port #(.ADDR_W(ADDR_W), .SEED(SEED)) uut (
    .clk(clk), .rst(rst), .clr_pin(clr_pin), .step_pin(step_pin),
    .oe_n_pin(oe_n_pin), .prog_n_pin(prog_n_pin),
    .port_data(port_data), .port_drive(port_drive)
  );

  function automatic logic [7:0] expect_byte(input int a);
    int t;
    t = (a * 29) + (a / 16);
    return 8'(t % 256) ^ SEED;
  endfunction

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic step_pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) step_pin = 1'b1;
      wait_clk(3);
      @(negedge clk) step_pin = 1'b0;
      wait_clk(3);
      model_addr = (model_addr + 1) % DEPTH;
    end
  endtask

  task automatic clear_pulse();
    @(negedge clk) clr_pin = 1'b1;
    wait_clk(4);
    @(negedge clk) clr_pin = 1'b0;
    wait_clk(4);
    model_addr = 0;
  endtask

  // Driver: pushes the expected byte, then performs one output-enable read.
  task automatic do_read(input string req);
    exp_q.push_back(expect_byte(model_addr));
    tag_q.push_back(req);
    @(negedge clk) oe_n_pin = 1'b0;
    wait_clk(6);
    strobe <= 1'b1;
    @(posedge clk) strobe <= 1'b0;
    @(negedge clk) oe_n_pin = 1'b1;
    wait_clk(6);
  endtask

  // Monitor: pops and compares when the driver marks a sample point.
  always @(negedge clk) begin
    if (strobe) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {port_drive, port_data}, {1'b1, e});
    end
  end

  initial begin
    wait_clk(200000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_clk(4);
    @(negedge clk) rst = 1'b0;
    wait_clk(3);
    @(negedge clk);
    check("R1 reset drive/data", {port_drive, port_data}, 9'h000);
    check("R5 idle oe high", {port_drive, port_data}, 9'h000);

    do_read("R1 first read at location 0");

    for (int k = 0; k < 5; k++) begin
      step_pulse(1);
      do_read("R3 R4 sequential read");
    end

    do_read("R8 repeat read no step");
    do_read("R8 third read no step");

    // long-held step: one advance only
    @(negedge clk) step_pin = 1'b1;
    wait_clk(20);
    @(negedge clk) step_pin = 1'b0;
    wait_clk(4);
    model_addr = model_addr + 1;
    do_read("R3 held step counts once");

    clear_pulse();
    do_read("R2 clear returns to 0");

    // steps while clear held
    @(negedge clk) clr_pin = 1'b1;
    wait_clk(3);
    step_pulse(3);
    model_addr = 0;
    @(negedge clk) clr_pin = 1'b0;
    wait_clk(4);
    do_read("R7 steps ignored under clear");

    // clear and step rise together, clear released while step still high
    step_pulse(2);
    @(negedge clk) begin clr_pin = 1'b1; step_pin = 1'b1; end
    wait_clk(4);
    @(negedge clk) clr_pin = 1'b0;
    wait_clk(4);
    @(negedge clk) step_pin = 1'b0;
    wait_clk(4);
    model_addr = 0;
    do_read("R7 clear wins over same-cycle step");

    // program-control low blocks drive
    step_pulse(7);
    @(negedge clk) prog_n_pin = 1'b0;
    wait_clk(4);
    @(negedge clk) oe_n_pin = 1'b0;
    wait_clk(6);
    @(negedge clk);
    check("R5 prog low no drive", {port_drive, port_data}, 9'h000);
    @(negedge clk) oe_n_pin = 1'b1;
    @(negedge clk) prog_n_pin = 1'b1;
    wait_clk(6);
    @(negedge clk);
    check("R5 oe high no drive", {port_drive, port_data}, 9'h000);
    do_read("R5 R8 read after blocked enable");

    // walk forward and revisit an earlier location
    step_pulse(300);
    do_read("R4 deep location");
    clear_pulse();
    step_pulse(5);
    do_read("R2 revisit earlier location");

    // wrap
    clear_pulse();
    step_pulse(DEPTH - 1);
    do_read("R6 top address");
    step_pulse(1);
    do_read("R6 wrap to zero");
    step_pulse(1);
    do_read("R6 after wrap location 1");

    wait_clk(4);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule